// File: doc/BRIEF.md
# Coarse-Grain Two-Thread Switch Controller

This block decides which of two hardware threads owns a short in-order pipeline. One thread is chosen as the favoured thread while reset is held, and it owns the pipeline whenever it is not waiting on a long-latency memory miss. When the favoured thread reports such a miss, the controller gives the pipeline to the other thread. On that same edge it raises a single-cycle flush, because the pipeline is not split between threads and instructions in flight belong to the thread that is leaving. When the favoured thread's miss completes, the controller takes the pipeline back in the same way.

The controller keeps one outstanding-miss flag per thread. A flag is set by a miss-start strobe and cleared by a miss-return strobe. If both threads are waiting at once, the controller stalls: it drives no PC select and holds the thread ID until one of the misses returns. Short-latency events such as branch mispredicts or first-level cache misses are not inputs to the block and never cause a switch. All outputs are registered. The controller reacts on the clock edge that samples a strobe.

Top module: `cgs_thread_switch`

## Requirements
- R1: While `rst_n` is low, `pref_tid` is sampled. After reset, `active_tid` equals that value, `flush` and `stall` are 0, and both miss flags are clear.
- R2: Whenever the preferred thread has no outstanding miss, `active_tid` equals the preferred thread and `stall` is 0.
- R3: A `miss_start` pulse for the preferred thread while it is running, with the other thread free, makes `active_tid` the other thread on the same clock edge.
- R4: A `miss_return` for the preferred thread while the other thread runs makes `active_tid` the preferred thread again on the same clock edge.
- R5: `flush` is 1 for exactly the cycles in which `active_tid` differs from its value in the previous cycle, so each switch produces one single-cycle pulse.
- R6: If both threads have outstanding misses, `stall` is 1, `pc_sel` is 0, `flush` is 0 and `active_tid` holds. When the first miss returns, the thread it belongs to runs and `stall` returns to 0. A flush is issued only if that thread differs from the held ID.
- R7: Bit t of `miss_start` sets thread t's flag and bit t of `miss_return` clears it. If both arrive in the same cycle, the flag ends up set. A return for a thread whose flag is clear is ignored.
- R8: When `stall` is 0, `pc_sel` is one-hot, with bit `active_tid` set.
- R9: A miss on the non-preferred thread while the preferred thread runs does not change `active_tid` and raises no flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pref_tid | input | 1 | Preferred thread, sampled while reset is held |
| miss_start | input | 2 | Per-thread long-latency miss start strobe |
| miss_return | input | 2 | Per-thread long-latency miss completion strobe |
| active_tid | output | 1 | Thread that currently owns the pipeline |
| flush | output | 1 | One-cycle pulse, high in the cycle the owner changes |
| stall | output | 1 | Both threads are waiting on misses |
| pc_sel | output | 2 | One-hot PC-source select, zero while stalled |

## Verification
A corrupted miss flag cannot be seen directly at the ports. It shows up on the next edge where the flags decide ownership. A favoured thread that is wrongly marked busy gives the pipeline away with a spurious flush. A flag wrongly marked clear keeps a waiting thread running or hides a stall. The bench models the flags independently and compares the ID, flush, stall and PC select every cycle, so any such error is caught in the cycle it first changes an output. Directed sequences also force simultaneous start and return strobes and returns with no pending miss, so flag errors that stay hidden under random traffic are exposed.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  localparam int NTHR = 2;
  localparam int TIDW = $clog2(NTHR);

  typedef logic [TIDW-1:0] tid_t;

  typedef struct packed {
    logic run;
    tid_t tid;
  } pick_t;

  // Ownership choice: favoured thread unless it waits; else the other; else none.
  function automatic pick_t pick_owner(logic [NTHR-1:0] busy, tid_t fav);
    pick_t p;
    tid_t  alt;
    alt   = ~fav;
    p.run = 1'b1;
    p.tid = fav;
    if (busy[fav]) begin
      if (!busy[alt]) p.tid = alt;
      else            p.run = 1'b0;
    end
    return p;
  endfunction

  function automatic logic [NTHR-1:0] tid_onehot(tid_t t, logic en);
    return en ? (NTHR'(1) << t) : '0;
  endfunction
endpackage

// File: rtl/cgs_miss_track.sv
module cgs_miss_track #(
  parameter int NT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] set_i,
  input  logic [NT-1:0] clr_i,
  output logic [NT-1:0] busy_q,
  output logic [NT-1:0] busy_nxt
);
  for (genvar t = 0; t < NT; t++) begin : g_thr
    // start wins over return; return on a clear flag has nothing to clear
    assign busy_nxt[t] = set_i[t] | (busy_q[t] & ~clr_i[t]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q[t] <= 1'b0;
      else        busy_q[t] <= busy_nxt[t];
    end
  end
endmodule

// File: rtl/cgs_switch_fsm.sv
module cgs_switch_fsm
  import cgs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  tid_t            fav_in,
  input  logic [NTHR-1:0] busy_nxt,
  output tid_t            fav_q,
  output tid_t            act_q,
  output logic            flush_q,
  output logic            stall_q
);
  pick_t pk;
  tid_t  act_nxt;
  logic  flush_nxt;

  always_comb begin
    pk        = pick_owner(busy_nxt, fav_q);
    act_nxt   = pk.run ? pk.tid : act_q;
    flush_nxt = pk.run && (pk.tid != act_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fav_q   <= fav_in;
      act_q   <= fav_in;
      flush_q <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      act_q   <= act_nxt;
      flush_q <= flush_nxt;
      stall_q <= !pk.run;
    end
  end
endmodule

// File: rtl/cgs_thread_switch.sv
module cgs_thread_switch
  import cgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pref_tid,
  input  logic [1:0] miss_start,
  input  logic [1:0] miss_return,
  output logic       active_tid,
  output logic       flush,
  output logic       stall,
  output logic [1:0] pc_sel
);
  logic [NTHR-1:0] busy_q;
  logic [NTHR-1:0] busy_nxt;
  tid_t            fav_q;

  cgs_miss_track #(.NT(NTHR)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (miss_start),
    .clr_i    (miss_return),
    .busy_q   (busy_q),
    .busy_nxt (busy_nxt)
  );

  cgs_switch_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .fav_in   (pref_tid),
    .busy_nxt (busy_nxt),
    .fav_q    (fav_q),
    .act_q    (active_tid),
    .flush_q  (flush),
    .stall_q  (stall)
  );

  assign pc_sel = tid_onehot(active_tid, !stall);
endmodule

// File: rtl/cgs_switch_checker.sv
module cgs_switch_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       act,
  input logic       flush,
  input logic       stall,
  input logic [1:0] pc_sel,
  input logic [1:0] busy,
  input logic       fav
);
  a_r5_change_has_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (act != $past(act)) |-> flush);
  a_r5_flush_has_change: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (act != $past(act)));
  a_r6_stall_both_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (busy == 2'b11));
  a_r6_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (pc_sel == 2'b00 && !flush));
  a_r6_stall_holds_id: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> $stable(act));
  a_r8_pc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> ($countones(pc_sel) == 1 && pc_sel[act]));
  a_r2_fav_runs: assert property (@(posedge clk) disable iff (!rst_n)
    !busy[fav] |-> (act == fav && !stall));
endmodule

bind cgs_thread_switch cgs_switch_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .act    (active_tid),
  .flush  (flush),
  .stall  (stall),
  .pc_sel (pc_sel),
  .busy   (busy_q),
  .fav    (fav_q)
);

// File: tb/test_cgs_thread_switch.sv
`timescale 1ns/1ps
module test_cgs_thread_switch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pref_tid = 1'b0;
  logic [1:0] miss_start = 2'b00;
  logic [1:0] miss_return = 2'b00;
  logic       active_tid, flush, stall;
  logic [1:0] pc_sel;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cgs_thread_switch i_cgs_thread_switch (
    .clk(clk), .rst_n(rst_n), .pref_tid(pref_tid),
    .miss_start(miss_start), .miss_return(miss_return),
    .active_tid(active_tid), .flush(flush), .stall(stall), .pc_sel(pc_sel)
  );

  // Behavioural reference model
  int m_pref, m_act, m_flush, m_stall;
  int m_wait[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pref = pref_tid; m_act = pref_tid; m_flush = 0; m_stall = 0;
      m_wait[0] = 0; m_wait[1] = 0;
    end else begin
      int owner;
      for (int t = 0; t < 2; t++) begin
        if (miss_start[t]) m_wait[t] = 1;
        else if (miss_return[t]) m_wait[t] = 0;
      end
      if (m_wait[m_pref] == 0) owner = m_pref;
      else if (m_wait[1 - m_pref] == 0) owner = 1 - m_pref;
      else owner = -1;
      m_stall = (owner < 0);
      m_flush = (owner >= 0 && owner != m_act);
      if (owner >= 0) m_act = owner;
    end
  end

  task automatic chk(string req, string what, int actual, int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  // Every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "active_tid", active_tid, m_act);
      chk("R5", "flush", flush, m_flush);
      chk("R6", "stall", stall, m_stall);
      chk("R8", "pc_sel", pc_sel, m_stall ? 0 : (1 << m_act));
    end
  end

  task automatic step(logic [1:0] s, logic [1:0] r);
    miss_start = s;
    miss_return = r;
    @(negedge clk);
    miss_start = 2'b00;
    miss_return = 2'b00;
  endtask

  task automatic do_reset(logic p);
    rst_n = 1'b0;
    pref_tid = p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset active_tid", active_tid, p);
    chk("R1", "reset flush", flush, 0);
    chk("R1", "reset stall", stall, 0);
  endtask

  task automatic random_run(int n);
    for (int i = 0; i < n; i++) begin
      logic [1:0] s, r;
      s[0] = ($urandom_range(0, 7) == 0);
      s[1] = ($urandom_range(0, 7) == 0);
      r[0] = ($urandom_range(0, 5) == 0);
      r[1] = ($urandom_range(0, 5) == 0);
      step(s, r);
    end
    // drain pending misses
    step(2'b00, 2'b11);
  endtask

  initial begin
    @(negedge clk);
    do_reset(1'b0);
    step(2'b00, 2'b00);
    chk("R2", "idle owner", active_tid, 0);
    step(2'b10, 2'b00);
    chk("R9", "other miss keeps owner", active_tid, 0);
    chk("R9", "other miss no flush", flush, 0);
    step(2'b00, 2'b10);
    step(2'b00, 2'b01);
    chk("R7", "spurious return owner", active_tid, 0);
    chk("R7", "spurious return flush", flush, 0);
    step(2'b01, 2'b00);
    chk("R3", "switch away", active_tid, 1);
    chk("R5", "switch flush", flush, 1);
    step(2'b00, 2'b00);
    chk("R5", "flush single cycle", flush, 0);
    step(2'b10, 2'b00);
    chk("R6", "both busy stall", stall, 1);
    chk("R6", "stall pc_sel", pc_sel, 0);
    chk("R6", "stall holds id", active_tid, 1);
    step(2'b00, 2'b10);
    chk("R6", "resume same thread", active_tid, 1);
    chk("R6", "resume no flush", flush, 0);
    chk("R6", "resume clears stall", stall, 0);
    step(2'b00, 2'b01);
    chk("R4", "switch back", active_tid, 0);
    chk("R5", "switch back flush", flush, 1);
    step(2'b01, 2'b01);
    chk("R7", "start wins over return", active_tid, 1);
    step(2'b00, 2'b01);
    chk("R4", "return after tie", active_tid, 0);
    step(2'b01, 2'b00);
    step(2'b10, 2'b00);
    step(2'b00, 2'b01);
    chk("R6", "resume to favoured", active_tid, 0);
    chk("R6", "resume to favoured flush", flush, 1);
    chk("R8", "pc_sel favoured", pc_sel, 2'b01);
    step(2'b00, 2'b10);
    random_run(3000);

    do_reset(1'b1);
    step(2'b10, 2'b00);
    chk("R3", "favoured 1 switch away", active_tid, 0);
    chk("R8", "pc_sel thread 0", pc_sel, 2'b01);
    step(2'b00, 2'b10);
    chk("R4", "favoured 1 back", active_tid, 1);
    chk("R8", "pc_sel thread 1", pc_sel, 2'b10);
    random_run(3000);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule